// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block gives several requesters shared access to a single-port word memory. Each request carries a 3-bit opcode, a word address and two operands. The block can perform a plain load, a plain store, test-and-set, fetch-and-add, swap or compare-and-swap.

Every operation runs as a locked sequence. A round-robin arbiter accepts one request. The block then reads the addressed word and, when the opcode calls for it, writes the new value in the next cycle. No other requester can touch the memory between that read and that write. The response goes back to the accepted requester. It carries the word read from memory, a success flag for compare-and-swap, and an error flag for opcodes that are not defined.

A requester holds `req_valid_i` with its fields stable until it sees its `req_ready_o` bit high before a rising edge. It then waits for its `rsp_valid_o` bit.

Top module: `amo_unit`

## Requirements
- R1: Opcode 0 (load) returns the addressed word and leaves memory unchanged.
- R2: Opcode 1 (store) writes operand A to the address and returns the previous word.
- R3: Opcode 2 (test-and-set) returns the old word. It writes 1 when the old word is zero and otherwise leaves memory unchanged.
- R4: Opcode 3 (fetch-and-add) returns the old word and writes old + operand A, wrapped modulo 2^DW.
- R5: Opcode 4 (swap) writes operand A and returns the previous word.
- R6: Opcode 5 (compare-and-swap) compares operand A with the stored word. On a match it writes operand B and sets `rsp_ok_o`. On a mismatch it leaves memory unchanged and clears `rsp_ok_o`. In both cases it returns the word read. `rsp_ok_o` is 0 for every other opcode.
- R7: Opcodes 6 and 7 set `rsp_err_o`, return data 0 and write nothing. `rsp_err_o` is 0 for defined opcodes.
- R8: `rsp_valid_o` of the accepted requester is high for exactly one cycle. That cycle follows the second rising edge after the edge at which `req_ready_o` was high.
- R9: At most one `req_ready_o` bit is high at a time. No request is accepted while an operation is in flight, which covers the two cycles after acceptance.
- R10: Arbitration is round-robin. The search starts at the requester after the last one accepted, and requester 0 comes first after reset.
- R11: The memory write of an operation happens in the cycle right after its read, to the same address. Concurrent fetch-and-add requests to one address therefore return successive values.
- R12: After reset, every memory word is 0 and no response is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | N_REQ | Request pending, one bit per requester |
| req_op_i | input | 3*N_REQ | Opcode per requester |
| req_addr_i | input | AW*N_REQ | Word address per requester |
| req_opa_i | input | DW*N_REQ | Operand A (add value, store/swap data, expected value) |
| req_opb_i | input | DW*N_REQ | Operand B (compare-and-swap new value) |
| req_ready_o | output | N_REQ | Request accepted at the next rising edge |
| rsp_valid_o | output | N_REQ | Response valid for that requester |
| rsp_data_o | output | DW | Word read from memory (0 on error) |
| rsp_ok_o | output | 1 | Compare-and-swap succeeded |
| rsp_err_o | output | 1 | Undefined opcode |

## Verification
Two functions share one cycle: the response of a finished operation and the acceptance of the next waiting requester. The idle cycle that carries a response is also the first cycle in which a new grant can be given.

The bench provokes this overlap by raising all requesters at once with fetch-and-add to one word whose value is near the wrap point. In each of those cycles it checks the previous requester's response data and the next requester's `req_ready_o` together.

A wrong grant order, a dropped increment or a grant given while an operation is in flight would show up as a wrong returned value, a wrong ready bit or a wrong final word.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int OPW = 3;
  localparam logic [OPW-1:0] OP_LD  = 3'd0;
  localparam logic [OPW-1:0] OP_ST  = 3'd1;
  localparam logic [OPW-1:0] OP_TAS = 3'd2;
  localparam logic [OPW-1:0] OP_FAA = 3'd3;
  localparam logic [OPW-1:0] OP_SWP = 3'd4;
  localparam logic [OPW-1:0] OP_CAS = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } amo_state_e;
endpackage

// File: rtl/amo_rr_arb.sv
module amo_rr_arb #(
  parameter int N  = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] gnt_idx_o
);
  logic [IW-1:0] last_q;
  logic          found;

  always_comb begin
    found     = 1'b0;
    gnt_idx_o = '0;
    for (int k = 0; k < N; k++) begin
      int c;
      c = int'(last_q) + 1 + k;
      if (c >= N) c = c - N;
      if (c >= N) c = c - N;
      if (!found && req_i[c]) begin
        found     = 1'b1;
        gnt_idx_o = IW'(c);
      end
    end
    gnt_o = '0;
    if (en_i && found) gnt_o[gnt_idx_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= IW'(N - 1);
    else if (en_i && found) last_q <= gnt_idx_o;
  end

  // granted requester must actually be requesting
  p_gnt_has_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o & ~req_i) == '0));
  // a requesting line may not be skipped when the unit is free
  p_gnt_when_free_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (req_i != '0)) |-> $onehot(gnt_o));
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  old_i,
  input  logic [DW-1:0]  opa_i,
  input  logic [DW-1:0]  opb_i,
  output logic [DW-1:0]  new_o,
  output logic           wr_o,
  output logic           ok_o,
  output logic           err_o
);
  always_comb begin
    new_o = old_i;
    wr_o  = 1'b0;
    ok_o  = 1'b0;
    err_o = 1'b0;
    unique case (op_i)
      OP_LD:  ;
      OP_ST:  begin wr_o = 1'b1; new_o = opa_i; end
      OP_TAS: begin wr_o = (old_i == '0); new_o = DW'(1); end
      OP_FAA: begin wr_o = 1'b1; new_o = old_i + opa_i; end
      OP_SWP: begin wr_o = 1'b1; new_o = opa_i; end
      OP_CAS: begin
        ok_o  = (old_i == opa_i);
        wr_o  = ok_o;
        new_o = opb_i;
      end
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/amo_mem.sv
module amo_mem #(
  parameter int DW = 8,
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_o <= '0;
    end else if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_o <= mem_q[addr_i];
    end
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int N_REQ = 3,
  parameter int DW    = 8,
  parameter int AW    = 4,
  localparam int IW   = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_REQ-1:0]     req_valid_i,
  input  logic [N_REQ*OPW-1:0] req_op_i,
  input  logic [N_REQ*AW-1:0]  req_addr_i,
  input  logic [N_REQ*DW-1:0]  req_opa_i,
  input  logic [N_REQ*DW-1:0]  req_opb_i,
  output logic [N_REQ-1:0]     req_ready_o,
  output logic [N_REQ-1:0]     rsp_valid_o,
  output logic [DW-1:0]        rsp_data_o,
  output logic                 rsp_ok_o,
  output logic                 rsp_err_o
);
  amo_state_e     state_q;
  logic [IW-1:0]  idx_q, gnt_idx;
  logic [OPW-1:0] op_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  opa_q, opb_q;
  logic [N_REQ-1:0] gnt;

  logic          mem_en, mem_we;
  logic [DW-1:0] mem_rdata, alu_new;
  logic          alu_wr, alu_ok, alu_err;

  amo_rr_arb #(.N(N_REQ)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (state_q == ST_IDLE),
    .req_i     (req_valid_i),
    .gnt_o     (gnt),
    .gnt_idx_o (gnt_idx)
  );

  amo_alu #(.DW(DW)) u_alu (
    .op_i  (op_q),
    .old_i (mem_rdata),
    .opa_i (opa_q),
    .opb_i (opb_q),
    .new_o (alu_new),
    .wr_o  (alu_wr),
    .ok_o  (alu_ok),
    .err_o (alu_err)
  );

  assign mem_we = (state_q == ST_WR) && alu_wr;
  assign mem_en = (state_q == ST_RD) || mem_we;

  amo_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (mem_en),
    .we_i    (mem_we),
    .addr_i  (addr_q),
    .wdata_i (alu_new),
    .rdata_o (mem_rdata)
  );

  assign req_ready_o = gnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      opa_q   <= '0;
      opb_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (gnt != '0) begin
          state_q <= ST_RD;
          idx_q   <= gnt_idx;
          op_q    <= req_op_i[int'(gnt_idx)*OPW +: OPW];
          addr_q  <= req_addr_i[int'(gnt_idx)*AW +: AW];
          opa_q   <= req_opa_i[int'(gnt_idx)*DW +: DW];
          opb_q   <= req_opb_i[int'(gnt_idx)*DW +: DW];
        end
        ST_RD:   state_q <= ST_WR;
        ST_WR:   state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= '0;
      rsp_data_o  <= '0;
      rsp_ok_o    <= 1'b0;
      rsp_err_o   <= 1'b0;
    end else if (state_q == ST_WR) begin
      rsp_valid_o        <= '0;
      rsp_valid_o[idx_q] <= 1'b1;
      rsp_data_o         <= alu_err ? '0 : mem_rdata;
      rsp_ok_o           <= alu_ok;
      rsp_err_o          <= alu_err;
    end else begin
      rsp_valid_o <= '0;
      rsp_ok_o    <= 1'b0;
      rsp_err_o   <= 1'b0;
    end
  end

  p_one_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o));
  p_busy_no_grant_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o != '0) |=> (req_ready_o == '0) ##1 (req_ready_o == '0));
  p_rsp_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o != '0) |-> ##3 (rsp_valid_o == $past(req_ready_o, 3)));
  p_one_rsp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rsp_valid_o));
  p_rmw_pair_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> ($past(mem_en && !mem_we) && ($past(addr_q) == addr_q)));
  p_err_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> !$past(mem_we));
  p_ok_only_cas_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ok_o |-> ($past(op_q) == OP_CAS) && $past(mem_we));
endmodule

// File: tb/tb_amo_unit.sv
`timescale 1ns/1ps
module tb_amo_unit;
  localparam int N = 3, DW = 8, AW = 4, OPW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]     valid = '0;
  logic [N*OPW-1:0] op_v  = '0;
  logic [N*AW-1:0]  ad_v  = '0;
  logic [N*DW-1:0]  a_v   = '0, b_v = '0;
  logic [N-1:0]     ready, rvalid;
  logic [DW-1:0]    rdata;
  logic             rok, rerr;

  int checks = 0, fails = 0;
  int last = N - 1;
  logic [DW-1:0] sh [16];
  bit done = 0;

  always #10 clk = ~clk;

  amo_unit #(.N_REQ(N), .DW(DW), .AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_op_i(op_v),
    .req_addr_i(ad_v), .req_opa_i(a_v), .req_opb_i(b_v), .req_ready_o(ready),
    .rsp_valid_o(rvalid), .rsp_data_o(rdata), .rsp_ok_o(rok), .rsp_err_o(rerr));

  task automatic chk(bit c, string tag, int act, int exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic setreq(int r, logic [2:0] op, logic [3:0] ad, logic [7:0] a, logic [7:0] b);
    op_v[r*OPW +: OPW] = op;
    ad_v[r*AW +: AW]   = ad;
    a_v[r*DW +: DW]    = a;
    b_v[r*DW +: DW]    = b;
  endtask

  task automatic do_op(int r, logic [2:0] op, logic [3:0] ad, logic [7:0] a, logic [7:0] b,
                       output logic [7:0] d, output logic ok, output logic err);
    @(negedge clk);
    setreq(r, op, ad, a, b);
    valid[r] = 1'b1;
    #1;
    chk(ready == N'(1 << r), "R10", int'(ready), 1 << r);
    @(posedge clk);
    last = r;
    @(negedge clk);
    valid[r] = 1'b0;
    #1 chk(ready == '0, "R9", int'(ready), 0);
    @(negedge clk);
    @(negedge clk);
    chk(rvalid == N'(1 << r), "R8", int'(rvalid), 1 << r);
    d = rdata; ok = rok; err = rerr;
    @(negedge clk);
    chk(rvalid == '0, "R8", int'(rvalid), 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=0 exp=1");
      report();
    end
  end

  initial begin
    logic [7:0] vals [6];
    string tags [8];
    logic [7:0] d, pre, a, b, nv, ev;
    logic ok, err, wr, eok, eerr;
    vals = '{8'h00, 8'h01, 8'h7f, 8'h80, 8'hfe, 8'hff};
    tags = '{"R1", "R2", "R3", "R4", "R5", "R6", "R7", "R7"};
    for (int i = 0; i < 16; i++) sh[i] = '0;

    #35 rst_n = 1'b1;
    @(negedge clk);
    chk(rvalid == '0, "R12", int'(rvalid), 0);
    chk(ready == '0, "R12", int'(ready), 0);
    for (int i = 0; i < 16; i++) begin
      do_op(i % N, 3'd0, 4'(i), 8'h00, 8'h00, d, ok, err);
      chk(d == 8'h00, "R12", int'(d), 0);
    end

    // sweep: every requester, every opcode, boundary operand values
    for (int r = 0; r < N; r++)
      for (int op = 0; op < 8; op++)
        for (int v = 0; v < 6; v++) begin
          logic [3:0] ad;
          ad  = 4'((r * 5 + op * 3 + v) % 16);
          pre = vals[(v + op) % 6];
          a   = (v % 2 == 1) ? pre : vals[v];
          b   = vals[(v + 2) % 6];
          do_op(r, 3'd1, ad, pre, 8'h00, d, ok, err);
          chk(d == sh[ad], "R2", int'(d), int'(sh[ad]));
          sh[ad] = pre;
          // expected from the requirement text
          nv = sh[ad]; wr = 0; eok = 0; eerr = 0; ev = sh[ad];
          case (op)
            0: ;
            1: begin wr = 1; nv = a; end
            2: begin wr = (sh[ad] == 0); nv = 8'h01; end
            3: begin wr = 1; nv = 8'((int'(sh[ad]) + int'(a)) % 256); end
            4: begin wr = 1; nv = a; end
            5: begin eok = (sh[ad] == a); wr = eok; nv = b; end
            default: begin eerr = 1; ev = 8'h00; end
          endcase
          do_op(r, 3'(op), ad, a, b, d, ok, err);
          chk(d == ev, tags[op], int'(d), int'(ev));
          chk(ok == eok, "R6", int'(ok), int'(eok));
          chk(err == eerr, "R7", int'(err), int'(eerr));
          if (wr) sh[ad] = nv;
          do_op(r, 3'd0, ad, 8'h00, 8'h00, d, ok, err);
          chk(d == sh[ad], tags[op], int'(d), int'(sh[ad]));
        end

    // contention: simultaneous fetch-and-add, two masks
    for (int round = 0; round < 2; round++) begin
      logic [N-1:0] mask, pend;
      int served;
      mask = (round == 0) ? 3'b111 : 3'b101;
      do_op(1, 3'd1, 4'd9, 8'hfe, 8'h00, d, ok, err);
      sh[9] = 8'hfe;
      @(negedge clk);
      for (int r = 0; r < N; r++) if (mask[r]) setreq(r, 3'd3, 4'd9, 8'h01, 8'h00);
      valid = mask;
      pend = mask;
      served = 0;
      while (served < $countones(mask)) begin
        int e;
        #1;
        e = -1;
        for (int k = 1; k <= N; k++)
          if (e < 0 && pend[(last + k) % N]) e = (last + k) % N;
        chk(ready == N'(1 << e), "R10", int'(ready), 1 << e);
        @(posedge clk);
        last = e;
        @(negedge clk);
        valid[e] = 1'b0;
        pend[e]  = 1'b0;
        #1 chk(ready == '0, "R9", int'(ready), 0);
        @(negedge clk);
        chk(ready == '0, "R9", int'(ready), 0);
        @(negedge clk);
        chk(rvalid == N'(1 << e), "R8", int'(rvalid), 1 << e);
        chk(rdata == sh[9], "R11", int'(rdata), int'(sh[9]));
        sh[9] = sh[9] + 8'h01;
        served++;
      end
      @(negedge clk);
      do_op(0, 3'd0, 4'd9, 8'h00, 8'h00, d, ok, err);
      chk(d == sh[9], "R4", int'(d), int'(sh[9]));
    end

    done = 1;
    report();
  end
endmodule